// File: doc/BRIEF.md
# Dual-Bank Input Gamma Lookup Table

This block maps each colour channel of an incoming pixel through a 256-entry transfer table. There are two copies of the table, called bank A and bank B, so that software can load a new curve into one bank while the other keeps serving live pixels. Each bank holds one 12-bit unsigned fraction (u0.12) per channel per entry. A pixel channel of `IN_W` bits keeps only its upper 8 bits as the table address. Any lower bits are dropped.

The host loads a bank through one data port. Successive accepted words go to the red, green and blue slots of the current entry in that order, and the entry index advances after blue. Before a load, software pulses an index clear, picks the target bank with a select bit and sets a per-channel write mask. The pixel path mode chooses bypass, bank A or bank B. In bypass, each channel's 8-bit address is widened to 12 bits by repeating its upper bits. A 3-bit status code reports the active bank together with the progress of the host load. A write aimed at the bank that is in use is dropped and raises a sticky error flag.

The host loader is a three-state machine. IDLE is entered on reset or on an index clear. IDLE goes to FILL on the first accepted write. FILL goes to DONE when the blue slot of entry 255 is written. DONE goes back to FILL on the next accepted write, which starts again at entry 0. An index clear sends FILL or DONE back to IDLE.

Top module: `gamma_lut`

## Requirements
- R1: While reset is asserted, `out_valid`, `out_r`, `out_g`, `out_b` and `wr_err` are 0, and the loader is in IDLE.
- R2: Each accepted host word goes to red, then green, then blue (channel codes 0, 1, 2) of the current entry, and the index advances by one after blue. `host_idx_clr` returns the loader to entry 0 and red, takes precedence over a write in the same cycle, and the write in that cycle is dropped.
- R3: `host_bank_sel` = 0 targets bank A and 1 targets bank B.
- R4: `mode` 2 reads bank A, `mode` 3 reads bank B, and `mode` 0 or 1 bypasses the table.
- R5: In a table mode, each output channel is the u0.12 entry addressed by bits [IN_W-1:IN_W-8] of the matching input channel.
- R6: In bypass, each output channel equals {a[7:0], a[7:4]}, where a is the 8-bit address of that channel.
- R7: `out_valid` and the outputs appear exactly one cycle after `pix_valid`. The outputs hold their value while `out_valid` is low.
- R8: `host_ch_mask` bit 0 enables red, bit 1 green and bit 2 blue. A masked slot still advances the loader but leaves the stored entry unchanged.
- R9: A host write while `mode` selects the target bank stores nothing and does not advance the loader. It sets `wr_err` on the next cycle, and `wr_err` stays set until reset.
- R10: `status` is 0 in bypass. With bank A active it is 1 (IDLE), 3 (FILL) or 4 (DONE). With bank B active it is 2 (IDLE), 5 (FILL) or 6 (DONE).
- R11: The loader moves between IDLE, FILL and DONE exactly as described above.
- R12: Host writes to the inactive bank in any cycle never stall or alter pixel results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr_en | input | 1 | Host data word present |
| host_idx_clr | input | 1 | Reset loader to entry 0, red |
| host_bank_sel | input | 1 | Write target: 0 bank A, 1 bank B |
| host_ch_mask | input | 3 | Per-channel write enable (bit0 red, bit1 green, bit2 blue) |
| host_wr_data | input | DATA_W | u0.12 table word |
| mode | input | 2 | 0/1 bypass, 2 bank A, 3 bank B |
| pix_valid | input | 1 | Pixel present |
| pix_r | input | IN_W | Red input |
| pix_g | input | IN_W | Green input |
| pix_b | input | IN_W | Blue input |
| out_valid | output | 1 | Result present |
| out_r | output | DATA_W | Red result |
| out_g | output | DATA_W | Green result |
| out_b | output | DATA_W | Blue result |
| status | output | 3 | Active bank and loader progress code |
| wr_err | output | 1 | Sticky flag for a write to the active bank |

## Verification
The hardest case to reach is a full 768-word load into the inactive bank running at the same time as a continuous pixel stream from the other bank. A collision or stall only shows up under that overlap. The bench forks a complete bank B load against a stream of several hundred bank A pixels and scores every result. The FILL status codes are reached with a masked write that advances the loader without changing any entry. Rejected writes to the active bank are shown to leave both the table contents and the loader position unchanged.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
    localparam int NUM_CH = 3;

    localparam logic [1:0] MODE_BANK_A = 2'd2;
    localparam logic [1:0] MODE_BANK_B = 2'd3;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_DONE = 2'd2
    } load_state_e;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } color_ch_e;
endpackage

// File: rtl/gamma_lut_wr_seq.sv
module gamma_lut_wr_seq
    import gamma_lut_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              accept,
    output logic [ADDR_W-1:0] wr_idx,
    output color_ch_e         wr_ch,
    output load_state_e       ld_state
);
    load_state_e state_q;
    load_state_e state_d;
    logic        last_slot;

    assign last_slot = (wr_ch == CH_BLU) && (wr_idx == {ADDR_W{1'b1}});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LD_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LD_IDLE: if (!clr && accept) state_d = LD_FILL;
            LD_FILL: begin
                if (clr)                         state_d = LD_IDLE;
                else if (accept && last_slot)    state_d = LD_DONE;
            end
            LD_DONE: begin
                if (clr)         state_d = LD_IDLE;
                else if (accept) state_d = LD_FILL;
            end
            default: state_d = LD_IDLE;
        endcase
    end

    // write position outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            wr_ch  <= CH_RED;
        end else if (clr) begin
            wr_idx <= '0;
            wr_ch  <= CH_RED;
        end else if (accept) begin
            unique case (wr_ch)
                CH_RED:  wr_ch <= CH_GRN;
                CH_GRN:  wr_ch <= CH_BLU;
                CH_BLU: begin
                    wr_ch  <= CH_RED;
                    wr_idx <= wr_idx + 1'b1;
                end
                default: wr_ch <= CH_RED;
            endcase
        end
    end

    assign ld_state = state_q;
endmodule

// File: rtl/gamma_lut_bank.sv
module gamma_lut_bank
    import gamma_lut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic                           clk,
    input  logic [NUM_CH-1:0]              ch_we,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  rd_addr,
    output logic [NUM_CH-1:0][DATA_W-1:0]  rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [DATA_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (ch_we[g]) mem[wr_addr] <= wr_data;
        end

        assign rd_data[g] = mem[rd_addr[g]];
    end
endmodule

// File: rtl/gamma_lut_out_stage.sv
module gamma_lut_out_stage
    import gamma_lut_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pix_valid,
    input  logic [1:0]                     mode,
    input  logic [NUM_CH-1:0][ADDR_W-1:0]  rd_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  a_data,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  b_data,
    output logic                           out_valid,
    output logic [NUM_CH-1:0][DATA_W-1:0]  out_data
);
    localparam int REP_W = DATA_W - ADDR_W;

    logic [NUM_CH-1:0][DATA_W-1:0] pick;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
        always_comb begin
            unique case (mode)
                MODE_BANK_A: pick[g] = a_data[g];
                MODE_BANK_B: pick[g] = b_data[g];
                default:     pick[g] = {rd_addr[g], rd_addr[g][ADDR_W-1 -: REP_W]};
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= pix_valid;
            if (pix_valid) out_data <= pick;
        end
    end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
    import gamma_lut_pkg::*;
#(
    parameter int IN_W   = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic              host_idx_clr,
    input  logic              host_bank_sel,
    input  logic [2:0]        host_ch_mask,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [1:0]        mode,
    input  logic              pix_valid,
    input  logic [IN_W-1:0]   pix_r,
    input  logic [IN_W-1:0]   pix_g,
    input  logic [IN_W-1:0]   pix_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_r,
    output logic [DATA_W-1:0] out_g,
    output logic [DATA_W-1:0] out_b,
    output logic [2:0]        status,
    output logic              wr_err
);
    localparam int NUM_BANKS = 2;

    logic                                         target_busy;
    logic                                         accept;
    logic [ADDR_W-1:0]                            wr_idx;
    color_ch_e                                    wr_ch;
    load_state_e                                  ld_state;
    logic [NUM_CH-1:0]                            ch_hit;
    logic [NUM_CH-1:0][ADDR_W-1:0]                rd_addr;
    logic [NUM_BANKS-1:0][NUM_CH-1:0][DATA_W-1:0] bank_rd;
    logic [NUM_CH-1:0][DATA_W-1:0]                out_data;

    assign target_busy = ((mode == MODE_BANK_A) && !host_bank_sel) ||
                         ((mode == MODE_BANK_B) &&  host_bank_sel);
    assign accept      = host_wr_en && !host_idx_clr && !target_busy;
    assign ch_hit      = NUM_CH'(1) << wr_ch;

    assign rd_addr[0] = pix_r[IN_W-1 -: ADDR_W];
    assign rd_addr[1] = pix_g[IN_W-1 -: ADDR_W];
    assign rd_addr[2] = pix_b[IN_W-1 -: ADDR_W];

    gamma_lut_wr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (host_idx_clr),
        .accept   (accept),
        .wr_idx   (wr_idx),
        .wr_ch    (wr_ch),
        .ld_state (ld_state)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [NUM_CH-1:0] we;
        assign we = {NUM_CH{accept && (host_bank_sel == 1'(b))}} & host_ch_mask & ch_hit;

        gamma_lut_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
            .clk     (clk),
            .ch_we   (we),
            .wr_addr (wr_idx),
            .wr_data (host_wr_data),
            .rd_addr (rd_addr),
            .rd_data (bank_rd[b])
        );
    end

    gamma_lut_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .mode      (mode),
        .rd_addr   (rd_addr),
        .a_data    (bank_rd[0]),
        .b_data    (bank_rd[1]),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign out_r = out_data[0];
    assign out_g = out_data[1];
    assign out_b = out_data[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         wr_err <= 1'b0;
        else if (host_wr_en && target_busy) wr_err <= 1'b1;
    end

    always_comb begin
        status = 3'd0;
        unique case (mode)
            MODE_BANK_A: begin
                unique case (ld_state)
                    LD_IDLE: status = 3'd1;
                    LD_FILL: status = 3'd3;
                    LD_DONE: status = 3'd4;
                    default: status = 3'd1;
                endcase
            end
            MODE_BANK_B: begin
                unique case (ld_state)
                    LD_IDLE: status = 3'd2;
                    LD_FILL: status = 3'd5;
                    LD_DONE: status = 3'd6;
                    default: status = 3'd2;
                endcase
            end
            default: status = 3'd0;
        endcase
    end
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
    parameter int IN_W   = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic              host_bank_sel,
    input logic [1:0]        mode,
    input logic              pix_valid,
    input logic [IN_W-1:0]   pix_r,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_r,
    input logic [2:0]        status,
    input logic              wr_err
);
    function automatic logic [DATA_W-1:0] widen(input logic [IN_W-1:0] v);
        logic [ADDR_W-1:0] a;
        a = v[IN_W-1 -: ADDR_W];
        return {a, a[ADDR_W-1 -: (DATA_W - ADDR_W)]};
    endfunction

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |=> wr_err);
    assert_err_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en && (((mode == 2'd2) && !host_bank_sel) || ((mode == 2'd3) && host_bank_sel))
        |=> wr_err);
    assert_status_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < 2'd2) |-> (status == 3'd0));
    assert_status_bank_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |-> (status == 3'd1 || status == 3'd3 || status == 3'd4));
    assert_status_bank_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> (status == 3'd2 || status == 3'd5 || status == 3'd6));
    assert_bypass_widen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && (mode < 2'd2) |=> (out_r == widen($past(pix_r))));
endmodule

bind gamma_lut gamma_lut_chk #(.IN_W(IN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_wr_en    (host_wr_en),
    .host_bank_sel (host_bank_sel),
    .mode          (mode),
    .pix_valid     (pix_valid),
    .pix_r         (pix_r),
    .out_valid     (out_valid),
    .out_r         (out_r),
    .status        (status),
    .wr_err        (wr_err)
);

// File: tb/tb_gamma_lut.sv
`timescale 1ns/1ps
module tb_gamma_lut;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr_en, host_idx_clr, host_bank_sel;
    logic [2:0]  host_ch_mask;
    logic [11:0] host_wr_data;
    logic [1:0]  mode;
    logic        pix_valid;
    logic [9:0]  pix_r, pix_g, pix_b;
    logic        out_valid;
    logic [11:0] out_r, out_g, out_b;
    logic [2:0]  status;
    logic        wr_err;

    always #2.5 clk = ~clk;

    gamma_lut dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_idx_clr(host_idx_clr),
        .host_bank_sel(host_bank_sel), .host_ch_mask(host_ch_mask),
        .host_wr_data(host_wr_data), .mode(mode),
        .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .status(status), .wr_err(wr_err)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [11:0] mdl [0:1][0:2][0:255];
    int          tb_idx = 0;
    int          tb_ch  = 0;
    logic [35:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_ch(input logic [1:0] m, input int c, input logic [9:0] v);
        logic [7:0] a;
        a = v[9:2];
        if (m == 2'd2)      return mdl[0][c][a];
        else if (m == 2'd3) return mdl[1][c][a];
        else                return {a, a[7:4]};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected out_valid", 32'd1, 32'd0);
            end else begin
                logic [35:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({out_r, out_g, out_b} == e, t, {out_r, out_g, out_b}, e);
            end
        end
    end

    task automatic send_pix(input logic [9:0] r, input logic [9:0] g, input logic [9:0] b);
        @(negedge clk);
        pix_valid = 1'b1;
        pix_r = r; pix_g = g; pix_b = b;
        exp_q.push_back({exp_ch(mode, 0, r), exp_ch(mode, 1, g), exp_ch(mode, 2, b)});
        tag_q.push_back(mode >= 2'd2 ? "R5 table lookup" : "R6 bypass widen");
    endtask

    task automatic pix_idle();
        @(negedge clk);
        pix_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    task automatic host_clr();
        @(negedge clk);
        host_idx_clr = 1'b1;
        host_wr_en   = 1'b0;
        tb_idx = 0; tb_ch = 0;
        @(negedge clk);
        host_idx_clr = 1'b0;
    endtask

    // bench model of the loader (R2, R3, R8, R9)
    task automatic host_write(input bit bank, input logic [11:0] d, input logic [2:0] msk);
        bit busy;
        @(negedge clk);
        host_wr_en    = 1'b1;
        host_bank_sel = bank;
        host_wr_data  = d;
        host_ch_mask  = msk;
        busy = (mode == 2'd2 && !bank) || (mode == 2'd3 && bank);
        if (!busy) begin
            if (msk[tb_ch]) mdl[bank][tb_ch][tb_idx] = d;
            if (tb_ch == 2) begin tb_ch = 0; tb_idx = (tb_idx + 1) % 256; end
            else tb_ch++;
        end
    endtask

    task automatic host_idle();
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic load_bank(input bit bank, input int seed);
        host_clr();
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++)
                host_write(bank, 12'((i * (7 + 4 * bank) + c * 331 + seed) & 12'hFFF), 3'b111);
        host_idle();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        host_wr_en = 0; host_idx_clr = 0; host_bank_sel = 0;
        host_ch_mask = 3'b111; host_wr_data = '0; mode = 2'd0;
        pix_valid = 0; pix_r = '0; pix_g = '0; pix_b = '0;
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk({out_r, out_g, out_b} == '0, "R1 outputs in reset", {out_r, out_g, out_b}, 0);
        chk(wr_err == 1'b0, "R1 wr_err in reset", wr_err, 0);
        chk(status == 3'd0, "R1 R10 status in reset", status, 0);
        rst_n = 1'b1;

        // bypass, modes 0 and 1 (R4, R6, R7)
        for (int k = 0; k < 12; k++) send_pix(10'(k * 93), 10'(1023 - k * 85), 10'(k * 61 + 3));
        mode = 2'd1;
        for (int k = 0; k < 8; k++) send_pix(10'(k * 127 + 1), 10'(k * 45), 10'(1023 - k * 7));
        pix_idle();
        drain("R7 bypass drain");

        // load bank A in bypass (R2, R3)
        load_bank(1'b0, 5);
        mode = 2'd2;
        @(negedge clk);
        chk(status == 3'd4, "R10 R11 A active, load done", status, 4);
        for (int k = 0; k < 40; k++) send_pix(10'(k * 26), 10'((k * 26 + 300) % 1024), 10'(1023 - k * 26));
        send_pix(10'd1023, 10'd0, 10'd1023);
        pix_idle();
        drain("R5 bank A drain");

        host_clr();
        chk(status == 3'd1, "R11 clear to IDLE, A active", status, 1);

        // load bank B while bank A streams (R12)
        fork
            load_bank(1'b1, 2049);
            begin
                for (int k = 0; k < 300; k++) send_pix(10'(k * 17), 10'(k * 29), 10'(k * 41));
                pix_idle();
            end
        join
        drain("R12 concurrent drain");
        chk(status == 3'd4, "R11 B load done, A active", status, 4);

        // masked write advances without storing (R8, R11)
        host_write(1'b1, 12'hABC, 3'b000);
        host_idle();
        chk(status == 3'd3, "R8 R11 FILL after masked write", status, 3);
        host_clr();
        chk(status == 3'd1, "R11 IDLE after clear", status, 1);

        mode = 2'd3;
        @(negedge clk);
        chk(status == 3'd2, "R10 B active idle", status, 2);
        for (int k = 0; k < 40; k++) send_pix(10'(k * 25 + 2), 10'(1023 - k * 19), 10'(k * 11));
        send_pix(10'd0, 10'd1, 10'd3);
        pix_idle();
        drain("R5 R8 bank B drain");

        // write to active bank is dropped (R9)
        chk(wr_err == 1'b0, "R9 no error yet", wr_err, 0);
        host_write(1'b1, 12'h123, 3'b111);
        host_idle();
        chk(wr_err == 1'b1, "R9 error raised", wr_err, 1);
        chk(status == 3'd2, "R9 loader not advanced", status, 2);
        send_pix(10'd0, 10'd0, 10'd0);
        send_pix(10'd1023, 10'd512, 10'd3);
        pix_idle();
        drain("R9 bank B unchanged");

        // channel mask per slot and order (R2, R8, R3)
        host_clr();
        host_write(1'b0, 12'h0F1, 3'b101);
        host_write(1'b0, 12'h0F2, 3'b101);
        host_write(1'b0, 12'h0F3, 3'b101);
        host_write(1'b0, 12'h0E1, 3'b111);
        host_write(1'b0, 12'h0E2, 3'b111);
        host_write(1'b0, 12'h0E3, 3'b111);
        host_idle();
        chk(status == 3'd5, "R10 R11 B active, A filling", status, 5);
        mode = 2'd2;
        @(negedge clk);
        chk(status == 3'd3, "R10 A active, filling", status, 3);
        chk(wr_err == 1'b1, "R9 wr_err sticky", wr_err, 1);
        send_pix(10'd0, 10'd1, 10'd2);
        send_pix(10'd4, 10'd5, 10'd7);
        send_pix(10'd8, 10'd11, 10'd1020);
        pix_idle();
        drain("R2 R8 masked entries");

        mode = 2'd0;
        for (int k = 0; k < 6; k++) send_pix(10'(k * 170), 10'(k * 3), 10'(1023 - k * 200));
        pix_idle();
        drain("R6 final bypass");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule